// File: doc/BRIEF.md
# Compare Instruction Byte Decoder

This block takes an instruction stream one byte per clock and recognises the integer compare family. The stream is split into optional prefixes, an opcode, an optional ModRM byte and an immediate of one, two or four bytes. When the last byte of a compare is accepted, the block presents a descriptor one cycle later and then looks for prefixes again. The descriptor gives the operand size, which operand comes first, the two register indices, whether the second operand is an immediate, and that immediate sign-extended to the descriptor width. The recognised prefixes are lock (0xF0), operand-size (0x66) and REX (0x40..0x4F).

A front-end places the block after its byte fetch and reads the descriptor or the error pulse. Only register-direct ModRM is handled. Any other opcode ends the instruction with an error code, and so do a lock prefix and memory addressing. An error is reported on the cycle after the byte that reveals it. After that byte the block starts over at the next byte.

Top module: `cmp_insn_decoder`

## Requirements
- R1: After reset `descValid` and `errValid` are low. `byteReady` is high in every cycle after reset.
- R2: Accumulator forms. Opcode 0x3C compares register 0 at size 8 with a 1-byte immediate. Opcode 0x3D takes a 2-byte immediate at size 16 and a 4-byte immediate at sizes 32 and 64. Both forms report first = second = 0 and `descHasImm` = 1.
- R3: Group forms need ModRM reg = 7. Opcode 0x80 is size 8 with a 1-byte immediate. Opcode 0x81 takes a 2-byte immediate at size 16 and a 4-byte immediate otherwise. Opcode 0x83 takes a 1-byte immediate at the full size. All three report first = r/m, second = 0 and `descHasImm` = 1.
- R4: Register forms. Opcodes 0x38 and 0x39 report first = r/m, second = reg and `descSwap` = 0. Opcodes 0x3A and 0x3B report first = reg, second = r/m and `descSwap` = 1. Opcodes 0x38 and 0x3A are size 8. `descHasImm` is 0 for all four.
- R5: `descSize` is encoded as 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
  - The default size is 32.
  - 0x66 selects 16.
  - REX with bit 3 set selects 64, and this wins over 0x66.
  - A REX byte counts only when no 0x66 or 0xF0 follows it before the opcode.
- R6: REX bit 2 supplies bit 3 of the reg index. REX bit 0 supplies bit 3 of the r/m index.
- R7: Immediate bytes are taken least significant first. The value is sign-extended from its own width to `descImm`, so a 4-byte immediate at size 64 stays at most 32 bits wide before extension.
- R8: A lock prefix on a compare gives `errCode` 3 in place of a descriptor.
  - For 0x3C and 0x3D it is reported after the opcode byte.
  - For the other forms it is reported after the ModRM byte.
  - It takes precedence over a non-register mod field.
- R9: `errCode` 1 reports a byte that is not a recognised prefix or compare opcode, after that byte. It also reports a group opcode whose ModRM reg is not 7, after the ModRM byte, with or without a lock prefix.
- R10: `errCode` 2 reports a compare ModRM whose mod field (bits 7:6) is not 3, after the ModRM byte.
- R11: Each outcome is a one-cycle pulse of exactly one of `descValid` or `errValid`, in the cycle after the accepted byte that completes it. The next byte then starts a new instruction with all prefix state cleared.
- R12: A cycle with `byteValid` low advances nothing, whatever `byteData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | Byte offered this cycle |
| byteData | input | 8 | Instruction byte |
| byteReady | output | 1 | Byte accepted when high together with byteValid |
| descValid | output | 1 | Descriptor pulse |
| descSize | output | 2 | Operand size code |
| descSwap | output | 1 | First operand comes from the reg field |
| descFirst | output | 4 | First operand register index |
| descSecond | output | 4 | Second operand register index, 0 with an immediate |
| descHasImm | output | 1 | Second operand is the immediate |
| descImm | output | IMM_W | Sign-extended immediate |
| errValid | output | 1 | Error pulse |
| errCode | output | 2 | 1 not a compare, 2 unsupported addressing, 3 undefined (lock) |

## Verification
The bench builds the decoder with the default IMM_W of 64. At that width the sign extension of a 4-byte immediate under REX.W shows across the upper 32 bits. A 1-byte immediate extended to 64 bits can also be told apart from a zero-extended one.

The bench sends streams that cover all three immediate lengths, each prefix order and every error priority, both back to back and with idle cycles filled with a lock byte. The idle cycles show whether stray data is ignored.

// File: rtl/cmpdec_pkg.sv
package cmpdec_pkg;
  localparam int BYTE_W    = 8;
  localparam int IMM_BYTES = 4;
  localparam int IMM_BUF_W = BYTE_W * IMM_BYTES;
  localparam int LANE_W    = $clog2(IMM_BYTES);
  localparam int IDX_W     = 4;

  localparam logic [BYTE_W-1:0] PFX_LOCK  = 8'hF0;
  localparam logic [BYTE_W-1:0] PFX_OPSZ  = 8'h66;
  localparam logic [BYTE_W-1:0] OPC_MR8   = 8'h38;
  localparam logic [BYTE_W-1:0] OPC_MR    = 8'h39;
  localparam logic [BYTE_W-1:0] OPC_RM8   = 8'h3A;
  localparam logic [BYTE_W-1:0] OPC_RM    = 8'h3B;
  localparam logic [BYTE_W-1:0] OPC_ACC8  = 8'h3C;
  localparam logic [BYTE_W-1:0] OPC_ACC   = 8'h3D;
  localparam logic [BYTE_W-1:0] OPC_GRP8  = 8'h80;
  localparam logic [BYTE_W-1:0] OPC_GRP   = 8'h81;
  localparam logic [BYTE_W-1:0] OPC_GRPS8 = 8'h83;
  localparam logic [2:0]        GRP_CMP   = 3'd7;
  localparam logic [1:0]        MOD_REG   = 2'b11;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} opSize_e;
  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_NOTCMP = 2'd1, ERR_UNSUP = 2'd2, ERR_UD = 2'd3} errCode_e;
  typedef enum logic [1:0] {IMM_1B = 2'd0, IMM_2B = 2'd1, IMM_4B = 2'd2} immLen_e;

  typedef struct packed {
    logic              clrPfx;
    logic              setLock;
    logic              setOpSz;
    logic              setRex;
    logic              clrRex;
    logic              latchOp;
    logic              latchModrm;
    logic              putImm;
    logic [LANE_W-1:0] immIdx;
    immLen_e           immLen;
    logic              emitDesc;
    logic              emitErr;
    errCode_e          errCode;
  } strobe_t;
endpackage

// File: rtl/cmpdec_ctrl.sv
module cmpdec_ctrl
  import cmpdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              pfxLock,
  input  logic              pfxOpSz,
  input  logic              pfxRexW,
  output logic              byteReady,
  output strobe_t           stb
);
  typedef enum logic [1:0] {S_PFX, S_MODRM, S_IMM} state_e;

  state_e            st, stNext;
  logic              isGrpQ, isGrpD;
  immLen_e           lenQ, lenD, wideLen;
  logic [LANE_W-1:0] idxQ, idxD, lastIdx;
  logic              fire;

  assign byteReady = 1'b1;
  assign fire      = byteValid & byteReady;
  assign wideLen   = (pfxOpSz && !pfxRexW) ? IMM_2B : IMM_4B;

  always_comb begin
    unique case (lenQ)
      IMM_1B:  lastIdx = LANE_W'(0);
      IMM_2B:  lastIdx = LANE_W'(1);
      default: lastIdx = LANE_W'(IMM_BYTES - 1);
    endcase
  end

  always_comb begin
    stb        = '0;
    stb.immIdx = idxQ;
    stb.immLen = lenQ;
    stNext     = st;
    isGrpD     = isGrpQ;
    lenD       = lenQ;
    idxD       = idxQ;
    if (fire) begin
      unique case (st)
        S_PFX: begin
          if (byteData == PFX_LOCK) begin
            stb.setLock = 1'b1;
            stb.clrRex  = 1'b1;
          end else if (byteData == PFX_OPSZ) begin
            stb.setOpSz = 1'b1;
            stb.clrRex  = 1'b1;
          end else if (byteData[7:4] == 4'h4) begin
            stb.setRex = 1'b1;
          end else if (byteData == OPC_ACC8 || byteData == OPC_ACC) begin
            if (pfxLock) begin
              stb.emitErr = 1'b1;
              stb.errCode = ERR_UD;
              stb.clrPfx  = 1'b1;
            end else begin
              stb.latchOp = 1'b1;
              stNext      = S_IMM;
              idxD        = '0;
              lenD        = (byteData == OPC_ACC8) ? IMM_1B : wideLen;
            end
          end else if (byteData == OPC_MR8 || byteData == OPC_MR ||
                       byteData == OPC_RM8 || byteData == OPC_RM) begin
            stb.latchOp = 1'b1;
            stNext      = S_MODRM;
            isGrpD      = 1'b0;
          end else if (byteData == OPC_GRP8 || byteData == OPC_GRP || byteData == OPC_GRPS8) begin
            stb.latchOp = 1'b1;
            stNext      = S_MODRM;
            isGrpD      = 1'b1;
            idxD        = '0;
            lenD        = (byteData == OPC_GRP) ? wideLen : IMM_1B;
          end else begin
            stb.emitErr = 1'b1;
            stb.errCode = ERR_NOTCMP;
            stb.clrPfx  = 1'b1;
          end
        end
        S_MODRM: begin
          stb.latchModrm = 1'b1;
          stNext         = S_PFX;
          if (isGrpQ && byteData[5:3] != GRP_CMP) begin
            stb.emitErr = 1'b1;
            stb.errCode = ERR_NOTCMP;
            stb.clrPfx  = 1'b1;
          end else if (pfxLock) begin
            stb.emitErr = 1'b1;
            stb.errCode = ERR_UD;
            stb.clrPfx  = 1'b1;
          end else if (byteData[7:6] != MOD_REG) begin
            stb.emitErr = 1'b1;
            stb.errCode = ERR_UNSUP;
            stb.clrPfx  = 1'b1;
          end else if (isGrpQ) begin
            stNext = S_IMM;
          end else begin
            stb.emitDesc = 1'b1;
            stb.clrPfx   = 1'b1;
          end
        end
        S_IMM: begin
          stb.putImm = 1'b1;
          if (idxQ == lastIdx) begin
            stb.emitDesc = 1'b1;
            stb.clrPfx   = 1'b1;
            stNext       = S_PFX;
          end else begin
            idxD = idxQ + LANE_W'(1);
          end
        end
        default: stNext = S_PFX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_PFX;
      isGrpQ <= 1'b0;
      lenQ   <= IMM_1B;
      idxQ   <= '0;
    end else begin
      st     <= stNext;
      isGrpQ <= isGrpD;
      lenQ   <= lenD;
      idxQ   <= idxD;
    end
  end

  // R8: the immediate phase is never entered while a lock prefix is pending
  a_r8_imm_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IMM) |-> !pfxLock);
  // R12: an idle input cycle leaves the sequencing state untouched
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> ($stable(st) && $stable(idxQ)));
  // R7: the byte lane index stays within the selected immediate length
  a_r7_lane_bound: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IMM) |-> (idxQ <= lastIdx));
endmodule

// File: rtl/cmpdec_dp.sv
module cmpdec_dp
  import cmpdec_pkg::*;
#(
  parameter int IMM_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  strobe_t           stb,
  output logic              pfxLock,
  output logic              pfxOpSz,
  output logic              pfxRexW,
  output logic              descValid,
  output logic [1:0]        descSize,
  output logic              descSwap,
  output logic [IDX_W-1:0]  descFirst,
  output logic [IDX_W-1:0]  descSecond,
  output logic              descHasImm,
  output logic [IMM_W-1:0]  descImm,
  output logic              errValid,
  output logic [1:0]        errCode
);
  logic                 rexR, rexB;
  logic [BYTE_W-1:0]    opQ;
  logic [5:0]           modrmQ, modrmNow;
  logic [IMM_BUF_W-1:0] immQ, immNow;
  logic [IMM_W-1:0]     immExt;
  logic                 isByteOp, isAcc, isGrp, isSwap;
  opSize_e              sizeD;
  logic [IDX_W-1:0]     rmIdx, regIdx;

  assign modrmNow = stb.latchModrm ? byteData[5:0] : modrmQ;

  for (genvar lane = 0; lane < IMM_BYTES; lane++) begin : g_lane
    assign immNow[lane*BYTE_W +: BYTE_W] =
      (stb.putImm && stb.immIdx == LANE_W'(lane)) ? byteData : immQ[lane*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (stb.immLen)
      IMM_1B:  immExt = {{(IMM_W-8){immNow[7]}}, immNow[7:0]};
      IMM_2B:  immExt = {{(IMM_W-16){immNow[15]}}, immNow[15:0]};
      default: immExt = {{(IMM_W-IMM_BUF_W){immNow[IMM_BUF_W-1]}}, immNow};
    endcase
  end

  assign isByteOp = (opQ == OPC_MR8) || (opQ == OPC_RM8) || (opQ == OPC_ACC8) || (opQ == OPC_GRP8);
  assign isAcc    = (opQ == OPC_ACC8) || (opQ == OPC_ACC);
  assign isGrp    = (opQ == OPC_GRP8) || (opQ == OPC_GRP) || (opQ == OPC_GRPS8);
  assign isSwap   = (opQ == OPC_RM8) || (opQ == OPC_RM);
  assign rmIdx    = {rexB, modrmNow[2:0]};
  assign regIdx   = {rexR, modrmNow[5:3]};
  assign sizeD    = isByteOp ? SZ_8 : pfxRexW ? SZ_64 : pfxOpSz ? SZ_16 : SZ_32;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfxLock <= 1'b0;
      pfxOpSz <= 1'b0;
      pfxRexW <= 1'b0;
      rexR    <= 1'b0;
      rexB    <= 1'b0;
    end else if (stb.clrPfx) begin
      pfxLock <= 1'b0;
      pfxOpSz <= 1'b0;
      pfxRexW <= 1'b0;
      rexR    <= 1'b0;
      rexB    <= 1'b0;
    end else begin
      if (stb.setLock) pfxLock <= 1'b1;
      if (stb.setOpSz) pfxOpSz <= 1'b1;
      if (stb.setRex) begin
        pfxRexW <= byteData[3];
        rexR    <= byteData[2];
        rexB    <= byteData[0];
      end else if (stb.clrRex) begin
        pfxRexW <= 1'b0;
        rexR    <= 1'b0;
        rexB    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= '0;
      modrmQ <= '0;
      immQ   <= '0;
    end else begin
      if (stb.latchOp)    opQ    <= byteData;
      if (stb.latchModrm) modrmQ <= byteData[5:0];
      if (stb.putImm)     immQ   <= immNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descValid  <= 1'b0;
      descSize   <= SZ_8;
      descSwap   <= 1'b0;
      descFirst  <= '0;
      descSecond <= '0;
      descHasImm <= 1'b0;
      descImm    <= '0;
      errValid   <= 1'b0;
      errCode    <= ERR_NONE;
    end else begin
      descValid <= stb.emitDesc;
      errValid  <= stb.emitErr;
      errCode   <= stb.emitErr ? stb.errCode : ERR_NONE;
      if (stb.emitDesc) begin
        descSize   <= sizeD;
        descSwap   <= isSwap;
        descFirst  <= isAcc ? '0 : (isSwap ? regIdx : rmIdx);
        descSecond <= (isAcc || isGrp) ? '0 : (isSwap ? rmIdx : regIdx);
        descHasImm <= isAcc || isGrp;
        descImm    <= (isAcc || isGrp) ? immExt : '0;
      end
    end
  end

  // R11: one outcome per instruction, never a descriptor and an error together
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(descValid && errValid));
  // R11: every compare spans at least two bytes, so descriptors never touch
  a_r11_desc_gap: assert property (@(posedge clk) disable iff (!rstN)
    descValid |=> !descValid);
  // R2: an immediate operand leaves no second register index
  a_r2_imm_no_second: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descHasImm) |-> (descSecond == '0));
  // R4: the swapped order only belongs to the register-register forms
  a_r4_swap_no_imm: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descSwap) |-> !descHasImm);
endmodule

// File: rtl/cmp_insn_decoder.sv
module cmp_insn_decoder
  import cmpdec_pkg::*;
#(
  parameter int IMM_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             byteReady,
  output logic             descValid,
  output logic [1:0]       descSize,
  output logic             descSwap,
  output logic [3:0]       descFirst,
  output logic [3:0]       descSecond,
  output logic             descHasImm,
  output logic [IMM_W-1:0] descImm,
  output logic             errValid,
  output logic [1:0]       errCode
);
  strobe_t stb;
  logic    pfxLock, pfxOpSz, pfxRexW;

  cmpdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteData  (byteData),
    .pfxLock   (pfxLock),
    .pfxOpSz   (pfxOpSz),
    .pfxRexW   (pfxRexW),
    .byteReady (byteReady),
    .stb       (stb)
  );

  cmpdec_dp #(.IMM_W(IMM_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .byteData   (byteData),
    .stb        (stb),
    .pfxLock    (pfxLock),
    .pfxOpSz    (pfxOpSz),
    .pfxRexW    (pfxRexW),
    .descValid  (descValid),
    .descSize   (descSize),
    .descSwap   (descSwap),
    .descFirst  (descFirst),
    .descSecond (descSecond),
    .descHasImm (descHasImm),
    .descImm    (descImm),
    .errValid   (errValid),
    .errCode    (errCode)
  );
endmodule

// File: tb/tb_cmp_insn_decoder.sv
module tb_cmp_insn_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int IMM_W      = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             byteValid = 1'b0;
  logic [7:0]       byteData = 8'h00;
  logic             byteReady, descValid, descSwap, descHasImm, errValid;
  logic [1:0]       descSize, errCode;
  logic [3:0]       descFirst, descSecond;
  logic [IMM_W-1:0] descImm;

  cmp_insn_decoder #(.IMM_W(IMM_W)) dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .descValid(descValid), .descSize(descSize),
    .descSwap(descSwap), .descFirst(descFirst), .descSecond(descSecond),
    .descHasImm(descHasImm), .descImm(descImm), .errValid(errValid), .errCode(errCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit     isErr;
    int     err;
    int     size;
    bit     swap;
    int     first;
    int     second;
    bit     hasImm;
    longint imm;
    int     nbytes;
  } ref_t;

  int          checks = 0;
  int          errors = 0;
  logic [7:0]  stream[$];
  ref_t        pend;
  bit          pendOn = 0;
  string       pendTag = "R11";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic ref_t refDecode();
    ref_t r;
    int p = 0;
    bit lk = 0, o16 = 0, rw = 0, rr = 0, rb = 0, grp;
    logic [7:0] op, m;
    int n = 0, wide;
    longint v = 0;
    r = '{default: 0};
    forever begin
      op = stream[p];
      p++;
      if (op == 8'hF0) begin lk = 1; rw = 0; rr = 0; rb = 0; end
      else if (op == 8'h66) begin o16 = 1; rw = 0; rr = 0; rb = 0; end
      else if (op[7:4] == 4'h4) begin rw = op[3]; rr = op[2]; rb = op[0]; end
      else break;
    end
    wide = rw ? 3 : (o16 ? 1 : 2);
    r.nbytes = p;
    if (op == 8'h3C || op == 8'h3D) begin
      if (lk) begin r.isErr = 1; r.err = 3; return r; end
      r.size = (op == 8'h3C) ? 0 : wide;
      r.hasImm = 1;
      n = (op == 8'h3C) ? 1 : ((o16 && !rw) ? 2 : 4);
    end else if (op inside {8'h38, 8'h39, 8'h3A, 8'h3B, 8'h80, 8'h81, 8'h83}) begin
      m = stream[p];
      p++;
      r.nbytes = p;
      grp = op inside {8'h80, 8'h81, 8'h83};
      if (grp && m[5:3] != 3'd7) begin r.isErr = 1; r.err = 1; return r; end
      if (lk) begin r.isErr = 1; r.err = 3; return r; end
      if (m[7:6] != 2'b11) begin r.isErr = 1; r.err = 2; return r; end
      r.size = (op inside {8'h38, 8'h3A, 8'h80}) ? 0 : wide;
      if (grp) begin
        r.first = rb * 8 + int'(m[2:0]);
        r.hasImm = 1;
        n = (op == 8'h81) ? ((o16 && !rw) ? 2 : 4) : 1;
      end else begin
        r.swap = op inside {8'h3A, 8'h3B};
        r.first  = r.swap ? (rr * 8 + int'(m[5:3])) : (rb * 8 + int'(m[2:0]));
        r.second = r.swap ? (rb * 8 + int'(m[2:0])) : (rr * 8 + int'(m[5:3]));
      end
    end else begin
      r.isErr = 1; r.err = 1; return r;
    end
    for (int k = 0; k < n; k++) v = v | (longint'(stream[p + k]) << (8 * k));
    if (n > 0 && v[8 * n - 1]) v = v - (longint'(1) << (8 * n));
    r.imm = v;
    r.nbytes = p + n;
    return r;
  endfunction

  task automatic checkNow();
    chk(byteReady === 1'b1, "R1", "byteReady", longint'(byteReady), 1);
    if (!pendOn) begin
      chk(descValid === 1'b0 && errValid === 1'b0, "R11", "idle valid",
          longint'({descValid, errValid}), 0);
    end else if (pend.isErr) begin
      chk(errValid === 1'b1 && descValid === 1'b0, pendTag, "error pulse",
          longint'({descValid, errValid}), 1);
      chk(errCode == 2'(pend.err), pendTag, "errCode", longint'(errCode), pend.err);
    end else begin
      chk(descValid === 1'b1 && errValid === 1'b0, pendTag, "desc pulse",
          longint'({descValid, errValid}), 2);
      chk(descSize == 2'(pend.size), pendTag, "size", longint'(descSize), pend.size);
      chk(descSwap == pend.swap, pendTag, "swap", longint'(descSwap), longint'(pend.swap));
      chk(descFirst == 4'(pend.first), pendTag, "first", longint'(descFirst), pend.first);
      chk(descSecond == 4'(pend.second), pendTag, "second", longint'(descSecond), pend.second);
      chk(descHasImm == pend.hasImm, pendTag, "hasImm", longint'(descHasImm), longint'(pend.hasImm));
      if (pend.hasImm)
        chk(descImm == 64'(pend.imm), pendTag, "imm", longint'(descImm), pend.imm);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow();
      byteValid = 1'b0;
      byteData  = 8'hF0;
      pendOn    = 0;
    end
  endtask

  task automatic runInsn(input string tag, input bit gaps);
    ref_t r;
    r = refDecode();
    for (int i = 0; i < r.nbytes; i++) begin
      if (gaps && i > 0) idle(1);
      @(negedge clk);
      checkNow();
      byteValid = 1'b1;
      byteData  = stream[i];
      pendOn    = (i == r.nbytes - 1);
      pend      = r;
      pendTag   = tag;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(descValid === 1'b0 && errValid === 1'b0, "R1", "valid in reset",
        longint'({descValid, errValid}), 0);
    rstN = 1'b1;
    idle(2);

    stream = {8'h3C, 8'h80};                          runInsn("R2", 0);
    stream = {8'h3D, 8'h34, 8'h12, 8'h00, 8'h80};     runInsn("R7", 0);
    stream = {8'h66, 8'h3D, 8'hFE, 8'hFF};            runInsn("R2", 0);
    stream = {8'h48, 8'h3D, 8'h00, 8'h00, 8'h00, 8'h80}; runInsn("R7", 0);
    stream = {8'h80, 8'hFB, 8'h7F};                   runInsn("R3", 0);
    stream = {8'h41, 8'h81, 8'hF9, 8'h78, 8'h56, 8'h34, 8'h12}; runInsn("R6", 0);
    stream = {8'h66, 8'h81, 8'hFA, 8'h00, 8'h80};     runInsn("R3", 0);
    stream = {8'h48, 8'h83, 8'hFF, 8'hFF};            runInsn("R3", 0);
    stream = {8'h83, 8'hF8, 8'h05};                   runInsn("R3", 0);
    stream = {8'h39, 8'hC8};                          runInsn("R4", 0);
    stream = {8'h4C, 8'h3B, 8'hD1};                   runInsn("R6", 0);
    stream = {8'h40, 8'h38, 8'hE3};                   runInsn("R4", 0);
    stream = {8'h45, 8'h3A, 8'hEE};                   runInsn("R4", 0);
    stream = {8'h48, 8'h66, 8'h39, 8'hC0};            runInsn("R5", 0);
    stream = {8'h66, 8'h48, 8'h39, 8'hC0};            runInsn("R5", 0);
    stream = {8'h66, 8'h39, 8'hC0};                   runInsn("R5", 0);
    stream = {8'h39, 8'hC0};                          runInsn("R11", 0);
    stream = {8'hF0, 8'h3C, 8'h01};                   runInsn("R8", 0);
    stream = {8'hF0, 8'h39, 8'hC0};                   runInsn("R8", 0);
    stream = {8'hF0, 8'h39, 8'h00};                   runInsn("R8", 0);
    stream = {8'h90};                                 runInsn("R9", 0);
    stream = {8'h0F};                                 runInsn("R9", 0);
    stream = {8'h80, 8'hC0, 8'h00};                   runInsn("R9", 0);
    stream = {8'hF0, 8'h80, 8'hC0};                   runInsn("R9", 0);
    stream = {8'h39, 8'h00};                          runInsn("R10", 0);
    stream = {8'h3B, 8'h45};                          runInsn("R10", 0);
    stream = {8'h3C, 8'h01};                          runInsn("R11", 0);
    stream = {8'h41, 8'h81, 8'hF9, 8'hEF, 8'hBE, 8'hAD, 8'hDE}; runInsn("R12", 1);
    stream = {8'h66, 8'h48, 8'h3D, 8'h11, 8'h22, 8'h33, 8'h44}; runInsn("R12", 1);
    stream = {8'h3B, 8'hC1};                          runInsn("R11", 0);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule